// File: doc/BRIEF.md
# Radix-64 Iterative Fraction Divider

This block divides one normalized floating fraction by another. It does not handle exponents, rounding, normalization or packing. A caller sets the format select and both fractions, then pulses `start` for one cycle. The unit latches the operands. It spends one setup cycle that forms the negated divisor and the integer quotient bit. It then runs one iteration per cycle, and each iteration retires six quotient bits. Each iteration is six chained non-restoring radix-2 steps. The sign of each new partial remainder gives one quotient bit.

The last bit of each six-bit group hangs on the deepest remainder sign. The accumulator therefore stores the group with that bit cleared and marks an increment as pending. It applies the increment when it folds in the next group. At the final iteration the increment is applied directly. The finished quotient appears right-aligned on `quotient` with a one-cycle `done` pulse, together with `sticky`, which reports a nonzero final remainder for later rounding.

Only one division runs at a time. `busy` stays high for the whole operation, and a `start` seen while busy is dropped and flagged on `proto_err`.

Top module: `div6_frac_divider`

## Requirements
- R1: After an accepted start, `busy` is high for exactly 7 cycles when `fmt`=0 (6 iterations), 12 cycles when `fmt`=1 (11 iterations), and 13 cycles when `fmt`=2 or 3 (12 iterations).
- R2: With N iterations, `quotient` equals floor(dividend·2^(6N) / divisor), right-aligned, with all bits above bit 6N at zero. Operands are taken as unsigned fractions with their top bit set.
- R3: `sticky` is 1 exactly when dividend·2^(6N) mod divisor is nonzero.
- R4: `done` is a one-cycle pulse in the first cycle after `busy` falls. `quotient` and `sticky` change only at that point and otherwise hold their value.
- R5: A `start` in a cycle where `busy` is high is ignored, so the running result is unchanged. `proto_err` is high in the following cycle only.
- R6: A `start` in the same cycle as `done` is accepted and begins a new division.
- R7: The setup cycle decides the integer quotient bit, bit 6N, as dividend ≥ divisor. Equal operands give exactly 2^(6N) with `sticky` 0.
- R8: The increment pending from one iteration is only ever added onto an accumulated quotient whose least significant bit is 0, so it never carries.
- R9: After reset, `busy`, `done`, `proto_err` and `sticky` are 0 and `quotient` is 0.
- R10: Operands are latched when a start is accepted. Changing `dividend`, `divisor` or `fmt` afterwards does not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start request, one cycle |
| fmt | input | 2 | Format select: 0 short, 1 long with wide exponent, 2/3 long with narrow exponent |
| dividend | input | FW | Dividend fraction, top bit set |
| divisor | input | FW | Divisor fraction, top bit set |
| busy | output | 1 | Division in progress |
| done | output | 1 | Result valid pulse |
| quotient | output | 6·IT_D+1 | Right-aligned quotient |
| sticky | output | 1 | Final remainder nonzero |
| proto_err | output | 1 | Start was dropped while busy |

## Verification
Two events can land in the same cycle: the `done` pulse that retires one division and the acceptance of the next `start`. The bench provokes this by issuing every follow-on division in the very cycle where it sees `done`. It then judges both the retired result and the new operation's busy length and quotient against values computed in the bench. A second overlap, a start arriving while the iterator runs, is injected mid-operation. For that case the bench checks that `proto_err` pulses and that the quotient still matches the original operands.

// File: rtl/div6_pkg.sv
package div6_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_ITER  = 2'd2
  } dstate_e;

  // iterations for a format code; codes 2 and 3 share the longest count
  function automatic int unsigned iter_count(input logic [1:0] f,
                                             input int unsigned n_s,
                                             input int unsigned n_g,
                                             input int unsigned n_d);
    case (f)
      2'd0:    return n_s;
      2'd1:    return n_g;
      default: return n_d;
    endcase
  endfunction

endpackage

// File: rtl/div6_ctrl.sv
module div6_ctrl
  import div6_pkg::*;
#(
  parameter int unsigned IT_S = 6,
  parameter int unsigned IT_G = 11,
  parameter int unsigned IT_D = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] fmt,
  output logic       accept,
  output logic       setup_step,
  output logic       iter_step,
  output logic       last_step,
  output logic       busy,
  output logic       done,
  output logic       proto_err
);
  localparam int unsigned CW = $clog2(IT_D + 1);

  dstate_e       state;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign busy       = (state != ST_IDLE);
  assign accept     = start && !busy;
  assign setup_step = (state == ST_SETUP);
  assign iter_step  = (state == ST_ITER);
  assign last_step  = iter_step && (cnt == lim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      lim       <= '0;
      done      <= 1'b0;
      proto_err <= 1'b0;
    end else begin
      done      <= 1'b0;
      proto_err <= start && busy;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_SETUP;
            cnt   <= '0;
            lim   <= CW'(iter_count(fmt, IT_S, IT_G, IT_D) - 1);
          end
        end
        ST_SETUP: state <= ST_ITER;
        ST_ITER: begin
          if (cnt == lim) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/div6_core.sv
module div6_core #(
  parameter int unsigned FW  = 56,
  parameter int unsigned DIG = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           accept,
  input  logic           setup_step,
  input  logic           iter_step,
  input  logic [FW-1:0]  a_in,
  input  logic [FW-1:0]  b_in,
  output logic           first_bit,
  output logic [DIG-1:0] digits,
  output logic           rem_nonzero
);
  localparam int unsigned RW = FW + 2;

  logic [FW-1:0] a_q;
  logic [RW-1:0] bpos_q;
  logic [RW-1:0] bneg_q;
  logic [RW-1:0] rem_q;
  logic [RW-1:0] rem_first;
  logic [RW-1:0] chain [0:DIG];

  // one non-restoring radix-2 step: subtract after a nonnegative remainder, add otherwise
  function automatic logic [RW-1:0] nr_step(input logic [RW-1:0] r,
                                            input logic [RW-1:0] bp,
                                            input logic [RW-1:0] bn);
    logic [RW-1:0] dbl;
    dbl = r << 1;
    return r[RW-1] ? (dbl + bp) : (dbl + bn);
  endfunction

  // a negative remainder of exactly -divisor means the true remainder is zero
  function automatic logic leftover(input logic [RW-1:0] r, input logic [RW-1:0] bn);
    return (r != '0) && (r != bn);
  endfunction

  assign rem_first = {2'b00, a_q} + bneg_q;
  assign first_bit = ~rem_first[RW-1];
  assign chain[0]  = rem_q;

  for (genvar i = 0; i < DIG; i++) begin : g_step
    assign chain[i+1]       = nr_step(chain[i], bpos_q, bneg_q);
    assign digits[DIG-1-i]  = ~chain[i+1][RW-1];
  end

  assign rem_nonzero = leftover(chain[DIG], bneg_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q    <= '0;
      bpos_q <= '0;
      bneg_q <= '0;
      rem_q  <= '0;
    end else begin
      if (accept) begin
        a_q    <= a_in;
        bpos_q <= {2'b00, b_in};
        bneg_q <= ~{2'b00, b_in} + RW'(1);
      end
      if (setup_step)     rem_q <= rem_first;
      else if (iter_step) rem_q <= chain[DIG];
    end
  end
endmodule

// File: rtl/div6_qacc.sv
module div6_qacc #(
  parameter int unsigned QW  = 73,
  parameter int unsigned DIG = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           setup_step,
  input  logic           iter_step,
  input  logic           last_step,
  input  logic           first_bit,
  input  logic [DIG-1:0] digits,
  input  logic           rem_nonzero,
  output logic [QW-1:0]  quotient,
  output logic           sticky,
  output logic           inc_pend,
  output logic           acc_lsb
);
  logic [QW-1:0] acc_q;

  // apply pending increment, then append a group whose low bit is left clear
  function automatic logic [QW-1:0] fold(input logic [QW-1:0] acc,
                                         input logic inc,
                                         input logic [DIG-1:0] grp);
    return ((acc + QW'(inc)) << DIG) | QW'({grp[DIG-1:1], 1'b0});
  endfunction

  assign acc_lsb = acc_q[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q    <= '0;
      inc_pend <= 1'b0;
      quotient <= '0;
      sticky   <= 1'b0;
    end else if (setup_step) begin
      acc_q    <= QW'(first_bit);
      inc_pend <= 1'b0;
    end else if (last_step) begin
      quotient <= fold(acc_q, inc_pend, digits) + QW'(digits[0]);
      sticky   <= rem_nonzero;
      inc_pend <= 1'b0;
    end else if (iter_step) begin
      acc_q    <= fold(acc_q, inc_pend, digits);
      inc_pend <= digits[0];
    end
  end
endmodule

// File: rtl/div6_frac_divider.sv
module div6_frac_divider #(
  parameter int unsigned FW   = 56,
  parameter int unsigned DIG  = 6,
  parameter int unsigned IT_S = 6,
  parameter int unsigned IT_G = 11,
  parameter int unsigned IT_D = 12,
  localparam int unsigned QW  = DIG * IT_D + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    fmt,
  input  logic [FW-1:0] dividend,
  input  logic [FW-1:0] divisor,
  output logic          busy,
  output logic          done,
  output logic [QW-1:0] quotient,
  output logic          sticky,
  output logic          proto_err
);
  logic           accept;
  logic           setup_step;
  logic           iter_step;
  logic           last_step;
  logic           first_bit;
  logic [DIG-1:0] digits;
  logic           rem_nonzero;
  logic           inc_pend;
  logic           acc_lsb;

  div6_ctrl #(.IT_S(IT_S), .IT_G(IT_G), .IT_D(IT_D)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .fmt(fmt),
    .accept(accept), .setup_step(setup_step), .iter_step(iter_step),
    .last_step(last_step), .busy(busy), .done(done), .proto_err(proto_err)
  );

  div6_core #(.FW(FW), .DIG(DIG)) u_core (
    .clk(clk), .rst_n(rst_n), .accept(accept), .setup_step(setup_step),
    .iter_step(iter_step), .a_in(dividend), .b_in(divisor),
    .first_bit(first_bit), .digits(digits), .rem_nonzero(rem_nonzero)
  );

  div6_qacc #(.QW(QW), .DIG(DIG)) u_qacc (
    .clk(clk), .rst_n(rst_n), .setup_step(setup_step), .iter_step(iter_step),
    .last_step(last_step), .first_bit(first_bit), .digits(digits),
    .rem_nonzero(rem_nonzero), .quotient(quotient), .sticky(sticky),
    .inc_pend(inc_pend), .acc_lsb(acc_lsb)
  );
endmodule

// File: rtl/div6_sva.sv
module div6_sva
  import div6_pkg::*;
#(
  parameter int unsigned IT_S = 6,
  parameter int unsigned IT_G = 11,
  parameter int unsigned IT_D = 12,
  parameter int unsigned QW   = 73
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [1:0]    fmt,
  input logic          busy,
  input logic          done,
  input logic          proto_err,
  input logic [QW-1:0] quotient,
  input logic          sticky,
  input logic          iter_step,
  input logic          inc_pend,
  input logic          acc_lsb
);
  logic [7:0] busy_cnt;
  logic [7:0] busy_want;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_cnt  <= '0;
      busy_want <= '0;
    end else begin
      if (start && !busy) busy_want <= 8'(iter_count(fmt, IT_S, IT_G, IT_D) + 1);
      busy_cnt <= busy ? busy_cnt + 8'd1 : 8'd0;
    end
  end

  assert_busy_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_cnt == busy_want));

  assert_done_after_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_result_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(quotient) && $stable(sticky)));

  assert_drop_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> proto_err);

  assert_flag_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> $past(start && busy));

  assert_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  assert_no_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (iter_step && inc_pend) |-> !acc_lsb);
endmodule

bind div6_frac_divider div6_sva #(
  .IT_S(IT_S), .IT_G(IT_G), .IT_D(IT_D), .QW(QW)
) u_sva (
  .clk(clk), .rst_n(rst_n), .start(start), .fmt(fmt), .busy(busy),
  .done(done), .proto_err(proto_err), .quotient(quotient), .sticky(sticky),
  .iter_step(iter_step), .inc_pend(inc_pend), .acc_lsb(acc_lsb)
);

// File: tb/div6_frac_divider_bench.sv
`timescale 1ns/1ps
module div6_frac_divider_bench;
  localparam int FW = 56;
  localparam int QW = 73;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    fmt = 2'd0;
  logic [FW-1:0] dividend = '0;
  logic [FW-1:0] divisor = '0;
  logic          busy, done, sticky, proto_err;
  logic [QW-1:0] quotient;

  int total = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  div6_frac_divider u_div6_frac_divider (
    .clk(clk), .rst_n(rst_n), .start(start), .fmt(fmt), .dividend(dividend),
    .divisor(divisor), .busy(busy), .done(done), .quotient(quotient),
    .sticky(sticky), .proto_err(proto_err)
  );

  function automatic int n_iter(input logic [1:0] f);
    return (f == 2'd0) ? 6 : (f == 2'd1) ? 11 : 12;
  endfunction

  function automatic logic [FW-1:0] rnd_frac();
    return {1'b1, 23'($urandom), 32'($urandom)};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // called at a negedge; leaves at the negedge of the done cycle
  task automatic run_div(input logic [1:0] f, input logic [FW-1:0] a,
                         input logic [FW-1:0] b, input bit poke);
    logic [127:0] num, q_exp, r_exp;
    int n, cyc;
    n     = n_iter(f);
    num   = {72'd0, a} << (6 * n);
    q_exp = num / {72'd0, b};
    r_exp = num % {72'd0, b};
    start = 1'b1; fmt = f; dividend = a; divisor = b;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0; fmt = ~f; dividend = ~a; divisor = {1'b1, b[FW-2:0] ^ 55'h1234};  // R10 scramble
    cyc = 0;
    while (busy && cyc < 40) begin
      cyc++;
      if (poke && cyc == 4) chk(proto_err == 1'b1, "R5 flag", 128'(proto_err), 128'd1);
      start = (poke && cyc == 3);
      @(negedge clk);
    end
    start = 1'b0;
    chk(cyc == n + 1, "R1 busy length", 128'(cyc), 128'(n + 1));
    chk(done == 1'b1, "R4 done after busy", 128'(done), 128'd1);
    chk(q_exp[127:QW] == '0 && quotient == q_exp[QW-1:0], "R2 quotient",
        128'(quotient), q_exp);
    chk(sticky == (r_exp != 0), "R3 sticky", 128'(sticky), 128'(r_exp != 0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [QW-1:0] held;
    logic [FW-1:0] ra, rb;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && proto_err == 0 && sticky == 0 && quotient == '0,
        "R9 reset state", {busy, done, proto_err, sticky}, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: equal operands -> exact power of two, no remainder
    for (int f = 0; f < 3; f++) begin
      run_div(2'(f), {1'b1, 55'h2AAA_5555_1234}, {1'b1, 55'h2AAA_5555_1234}, 1'b0);
      chk(quotient == (QW'(1) << (6 * n_iter(2'(f)))) && !sticky, "R7 equal operands",
          128'(quotient), 128'(QW'(1) << (6 * n_iter(2'(f)))));
    end
    // extremes: largest over smallest, smallest over largest, format code 3
    run_div(2'd2, {FW{1'b1}}, {1'b1, {(FW-1){1'b0}}}, 1'b0);
    run_div(2'd0, {1'b1, {(FW-1){1'b0}}}, {FW{1'b1}}, 1'b0);
    run_div(2'd3, {FW{1'b1}}, {1'b1, {(FW-2){1'b0}}, 1'b1}, 1'b0);

    // R5: start while busy, result must follow the original operands
    run_div(2'd1, rnd_frac(), rnd_frac(), 1'b1);

    // R4: result held while idle and inputs move
    held = quotient;
    repeat (6) begin
      @(negedge clk);
      dividend = rnd_frac();
    end
    chk(quotient == held && !done, "R4 hold", 128'(quotient), 128'(held));

    // random, back-to-back (R6: each follow-on start lands in the done cycle)
    for (int k = 0; k < 36; k++) begin
      ra = rnd_frac();
      rb = rnd_frac();
      if (k % 9 == 4) begin
        repeat (2) @(negedge clk);
      end
      run_div(2'($urandom_range(0, 3)), ra, rb, (k % 7 == 2));
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule